// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog made of a free-running prescaler and an 8-bit up-counter. The prescaler advances on a machine-cycle enable (one pulse per machine cycle, the oscillator divided by twelve). Each time the prescaler carries, the counter steps up by one. When the counter wraps from its maximum back to zero, the block raises a one-clock internal system reset and starts a reset-output pulse that lasts three machine cycles.

Software prevents the reset by reloading the counter before it wraps. A reload takes effect only when software has first raised a separate permission flag. That flag drops by itself on the reload, so every reload needs a fresh permission. The reloaded value sets the timeout: a value near the top gives a short interval and zero gives the longest. A reload also clears the prescaler, so the interval that follows is exact.

An external disable pin turns the watchdog off. While the pin is high, the counter, the prescaler and the flag are held cleared, and power-down is allowed. While the pin is low, the watchdog runs and power-down is refused. The watchdog takes no notice of the CPU idle state, so it keeps counting while the CPU is idle.

Top module: `wdg_guard`

## Requirements
- R1: The synchronous active-low reset clears the counter, the prescaler, the flag and both reset outputs. After reset, with no reload, the first system reset follows 256 × 2^PRE_W machine-cycle enables.
- R2: The counter steps once every 2^PRE_W machine-cycle enables. After a reload with value V, `sys_rst` goes high on the clock edge that consumes the (256−V)·2^PRE_W-th enable pulse. For example, V=0xFF gives one step and V=0x00 gives 256 steps.
- R3: A write (`wr_en` high) while the permission flag is clear leaves the counter and the prescaler unchanged.
- R4: A write that loads the counter also clears the permission flag. A second write without a new `arm_set` is ignored.
- R5: When `arm_set` and `wr_en` are high in the same cycle with the flag clear, the write is ignored and the flag becomes set for later writes.
- R6: A reload clears the prescaler, so earlier machine cycles do not shorten the new interval.
- R7: A reload that falls in the same cycle as a counter step or a wrap takes priority. The counter takes the written value and no system reset follows.
- R8: `rst_out` rises on the same edge as `sys_rst` and stays high for exactly 3 machine-cycle enable pulses, falling on the edge that consumes the third.
- R9: While `wd_off_pin` is high, the counter, the prescaler and the flag are held at zero, writes and `arm_set` have no effect, and no system reset occurs. `pd_allow` equals `wd_off_pin`.
- R10: A counter wrap clears the permission flag.
- R11: `sys_rst` is high for exactly one clock per wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_en | input | 1 | Machine-cycle enable, one pulse per machine cycle |
| wr_en | input | 1 | Write strobe for the counter |
| wr_data | input | CNT_W | Reload value for the counter |
| arm_set | input | 1 | Sets the reload permission flag |
| wd_off_pin | input | 1 | High disables the watchdog and allows power-down |
| sys_rst | output | 1 | One-clock internal system reset on a counter wrap |
| rst_out | output | 1 | Reset-output pulse, three machine cycles long |
| pd_allow | output | 1 | High when power-down mode is permitted |

## Verification
Two functions can fall in the same cycle: a software reload and the prescaler carry that would step the counter, or wrap it when the counter holds 0xFF. The bench provokes this by loading 0xFF and running the prescaler up to one enable short of its carry. It then writes 0x80 in a cycle where the machine-cycle enable is high. The case is judged at the ports. No system reset may appear, and the next reset must arrive after exactly 128 steps' worth of enable pulses counted from that write. A second overlap, permission set together with a write, is judged by the length of the timeout that results.

// File: rtl/wdg_pkg.sv
// Package wdg_pkg
// Shared types for the guarded watchdog. The pin state selects one of
// two operating modes; everything else is parameterised per instance.
package wdg_pkg;
    typedef enum logic {
        WD_RUN = 1'b0,   // watchdog counting, power-down refused
        WD_OFF = 1'b1    // watchdog held, power-down permitted
    } wd_mode_e;
endpackage

// File: rtl/wdg_prescale.sv
// Module wdg_prescale
// Free-running prescaler advanced by the machine-cycle enable. Emits a
// one-cycle step when it carries out of its top value.
// Assumes: clr and run are synchronous to clk; clr has priority over counting.
module wdg_prescale #(
    parameter int PRE_W = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic mc_en,
    input  logic clr,
    output logic step
);
    logic [PRE_W-1:0] pre_q;

    // Prescaler register: held at zero when off or on reload, else counts.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || clr)
            pre_q <= '0;
        else if (mc_en)
            pre_q <= pre_q + PRE_W'(1);
    end

    // Carry out: the enable pulse that takes the prescaler past its top.
    assign step = run && mc_en && (&pre_q);

    // R6
    pre_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre_q == '0));
endmodule

// File: rtl/wdg_count.sv
// Module wdg_count
// Watchdog up-counter. Loads the reload value, steps on prescaler carry
// and flags a wrap; the wrap is registered into a one-clock system reset.
// Assumes: load is already qualified by the permission flag and run.
module wdg_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             ovf,
    output logic             sys_rst
);
    logic [CNT_W-1:0] cnt_q;

    // Wrap detect: a step at the top value, cancelled by a same-cycle reload.
    assign ovf = step && (&cnt_q) && !load;

    // Counter register: zero when off, reload wins, else step.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (step)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // System reset register: one clock after each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sys_rst <= 1'b0;
        else
            sys_rst <= ovf;
    end

    // R11
    one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> !sys_rst);
    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> (cnt_q == '0));
    // R9
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
    // R7
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)) && !sys_rst);
endmodule

// File: rtl/wdg_arm.sv
// Module wdg_arm
// Reload permission flag. Set by software, dropped by the reload it
// permits, by a counter wrap, and while the watchdog is off.
// Assumes: a reload in the same cycle as a set request wins (flag clears).
module wdg_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic arm_set,
    input  logic load,
    input  logic ovf,
    output logic arm_q
);
    // Flag register: clear on reset/off/reload/wrap, else set on request.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || load || ovf)
            arm_q <= 1'b0;
        else if (arm_set)
            arm_q <= 1'b1;
    end

    // R4
    arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !arm_q);
    // R10
    arm_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !arm_q);
endmodule

// File: rtl/wdg_pulse.sv
// Module wdg_pulse
// Reset-output stretcher: on a fire request, drives its output high for
// PULSE_MC machine-cycle enable pulses.
// Assumes: fires are far apart (at least one full counter period).
module wdg_pulse #(
    parameter int PULSE_MC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mc_en,
    input  logic fire,
    output logic rst_out
);
    localparam int PW = $clog2(PULSE_MC + 1);
    logic [PW-1:0] left_q;

    // Remaining machine cycles of the pulse: reload on fire, count down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (fire)
            left_q <= PW'(PULSE_MC);
        else if (mc_en && left_q != '0)
            left_q <= left_q - PW'(1);
    end

    assign rst_out = (left_q != '0);

    // R8
    pulse_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> rst_out && (left_q == PW'(PULSE_MC)));
    // R8
    pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_out && !mc_en && !fire) |=> rst_out);
endmodule

// File: rtl/wdg_guard.sv
// Module wdg_guard (top)
// Guarded watchdog: prescaler, up-counter, reload permission flag and
// reset-output stretcher. The disable pin picks between watchdog and
// power-down. Assumes all inputs are synchronous to clk.
module wdg_guard
    import wdg_pkg::*;
#(
    parameter int PRE_W    = 11,
    parameter int CNT_W    = 8,
    parameter int PULSE_MC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mc_en,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             arm_set,
    input  logic             wd_off_pin,
    output logic             sys_rst,
    output logic             rst_out,
    output logic             pd_allow
);
    wd_mode_e mode;
    logic     run;
    logic     arm_q;
    logic     load;
    logic     step;
    logic     ovf;

    // Mode select from the pin.
    assign mode     = wd_off_pin ? WD_OFF : WD_RUN;
    assign run      = (mode == WD_RUN);
    assign pd_allow = (mode == WD_OFF);

    // A write becomes a reload only while running and permitted.
    assign load = run && wr_en && arm_q;

    wdg_arm u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .arm_set (arm_set),
        .load    (load),
        .ovf     (ovf),
        .arm_q   (arm_q)
    );

    wdg_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .mc_en (mc_en),
        .clr   (load),
        .step  (step)
    );

    wdg_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .step     (step),
        .load     (load),
        .load_val (wr_data),
        .ovf      (ovf),
        .sys_rst  (sys_rst)
    );

    wdg_pulse #(.PULSE_MC(PULSE_MC)) u_pls (
        .clk     (clk),
        .rst_n   (rst_n),
        .mc_en   (mc_en),
        .fire    (ovf),
        .rst_out (rst_out)
    );

    // R9
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_off_pin |=> !sys_rst);
    // R3
    no_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !arm_q) |-> !load);
endmodule

// File: tb/tb_wdg_guard.sv
module tb_wdg_guard;
    localparam int PW = 3;
    localparam int CW = 8;
    localparam int PM = 3;
    localparam int STEP_MC = 1 << PW;
    localparam int RUN_LIMIT = 6000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mc_en = 1'b0;
    logic wr_en = 1'b0;
    logic [CW-1:0] wr_data = '0;
    logic arm_set = 1'b0;
    logic wd_off_pin = 1'b0;
    logic sys_rst, rst_out, pd_allow;

    int n_run = 0;
    int n_fail = 0;
    int unsigned seed_dummy;

    wdg_guard #(.PRE_W(PW), .CNT_W(CW), .PULSE_MC(PM)) dut (
        .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .wr_en(wr_en),
        .wr_data(wr_data), .arm_set(arm_set), .wd_off_pin(wd_off_pin),
        .sys_rst(sys_rst), .rst_out(rst_out), .pd_allow(pd_allow));

    always #2 clk = ~clk;

    // Expected enable pulses from a reload of v to the system reset.
    function automatic int exp_timeout(int v);
        return STEP_MC * ((1 << CW) - v);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic restart();
        rst_n = 1'b0; mc_en = 0; wr_en = 0; arm_set = 0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic arm();
        arm_set = 1'b1; mc_en = 1'b0;
        tick();
        arm_set = 1'b0;
    endtask

    task automatic write(logic [CW-1:0] v, bit mc);
        wr_en = 1'b1; wr_data = v; mc_en = mc;
        tick();
        wr_en = 1'b0; mc_en = 1'b0;
    endtask

    // Random enables until sys_rst; returns enable pulses consumed.
    task automatic run_until_rst(output int mcs, output bit seen);
        mcs = 0; seen = 0;
        for (int i = 0; i < RUN_LIMIT; i++) begin
            mc_en = (($urandom % 4) != 0);
            tick();
            if (mc_en) mcs++;
            if (sys_rst) begin seen = 1; break; end
        end
        mc_en = 1'b0;
    endtask

    task automatic expect_timeout(int v, string req);
        int mcs; bit seen;
        run_until_rst(mcs, seen);
        check(seen, req, int'(seen), 1);
        check(mcs == exp_timeout(v), req, mcs, exp_timeout(v));
    endtask

    // Called right after sys_rst was seen high.
    task automatic check_pulse();
        int n = 0;
        check(rst_out == 1'b1, "R8 start", int'(rst_out), 1);
        for (int i = 0; i < 200; i++) begin
            if (!rst_out) break;
            mc_en = (($urandom % 2) != 0);
            tick();
            if (mc_en) n++;
            if (i == 0) check(sys_rst == 1'b0, "R11 width", int'(sys_rst), 0);
        end
        mc_en = 1'b0;
        check(n == PM, "R8 length", n, PM);
    endtask

    initial begin
        int k;
        int v;
        bit any;
        seed_dummy = $urandom(32'h5eed_0c0d);
        restart();
        // R1 reset state
        check(sys_rst == 1'b0, "R1 sys_rst", int'(sys_rst), 0);
        check(rst_out == 1'b0, "R1 rst_out", int'(rst_out), 0);
        check(pd_allow == 1'b0, "R9 pd_allow low", int'(pd_allow), 0);
        // R3: unpermitted write ignored, full timeout from reset (R1)
        write(8'hFF, 1'b0);
        expect_timeout(0, "R3 R1");
        check_pulse();

        // R4: reload drops the flag, second write ignored
        restart();
        arm(); write(8'hF0, 1'b0); write(8'hFF, 1'b0);
        expect_timeout(8'hF0, "R4");

        // R5: set and write together -> write ignored, next write loads
        restart();
        arm_set = 1'b1; write(8'hFF, 1'b0); arm_set = 1'b0;
        write(8'hFE, 1'b0);
        expect_timeout(8'hFE, "R5");

        // R7: reload coincides with wrap of counter at 0xFF
        restart();
        arm(); write(8'hFF, 1'b0);
        mc_en = 1'b1;
        repeat (STEP_MC - 1) tick();
        mc_en = 1'b0;
        check(sys_rst == 1'b0, "R7 pre", int'(sys_rst), 0);
        arm();
        write(8'h80, 1'b1);
        check(sys_rst == 1'b0, "R7 no reset", int'(sys_rst), 0);
        expect_timeout(8'h80, "R7");

        // R9: pin high holds everything off
        restart();
        wd_off_pin = 1'b1;
        tick();
        check(pd_allow == 1'b1, "R9 pd_allow high", int'(pd_allow), 1);
        arm(); write(8'hFF, 1'b0);
        any = 0;
        mc_en = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            tick();
            if (sys_rst) any = 1;
        end
        mc_en = 1'b0;
        check(!any, "R9 quiet", int'(any), 0);
        arm();
        wd_off_pin = 1'b0;
        tick();
        write(8'hFF, 1'b0);
        expect_timeout(0, "R9 held zero");

        // R10: wrap clears the flag
        restart();
        arm();
        expect_timeout(0, "R10 first");
        write(8'hFF, 1'b0);
        expect_timeout(0, "R10 after wrap");

        // R2 / R6: random values after random prescaler activity
        restart();
        for (int t = 0; t < 12; t++) begin
            k = $urandom % (STEP_MC * 2);
            mc_en = 1'b1;
            repeat (k) tick();
            mc_en = 1'b0;
            v = (t == 0) ? 255 : (t == 1) ? 0 : int'($urandom % 256);
            arm();
            write(CW'(v), 1'b0);
            expect_timeout(v, (k % STEP_MC != 0) ? "R6 R2" : "R2");
            check_pulse();
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule